// File: doc/BRIEF.md
# Debug Exit Sequencer

This controller governs how a halted processor core leaves debug state. While the core is halted, a debugger loads instructions into it through a scan chain. Each loaded instruction carries one extra control bit. When that bit is set, the instruction runs at system speed and is resynchronised to the bus clock enable. The sequencer follows these loads. It accepts a restart only after a valid closing pair: a system-speed instruction followed by a final branch with the bit clear.

When the restart instruction is selected in the JTAG TAP, the core does not resume at once. The block waits in a pending state until the TAP state machine next passes through Run-Test/Idle. This lets several cores, each armed in advance, restart on the same cycle.

A debug-acknowledge output stays high for the whole halt. Peripherals that count bus cycles or run in real time can use it to ignore the extra accesses the debugger causes. A resume pulse marks the cycle in which fetching restarts. A resynchronise flag reports the control bit of the most recently loaded instruction.

Top module: `dbg_exit_seq`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) puts the block in the running state with `dbg_ack`, `resume_pulse` and `resync_en` all low. A restart that was pending before the reset is dropped.
- R2: `dbg_req` high at an edge while running makes `dbg_ack` high after that edge. While halted or pending, `dbg_req` has no effect.
- R3: While halted in debug, `scan_cap` high at an edge stores `scan_sys_bit` into `resync_en` after that edge. Without a capture, `resync_en` holds its value. Captures while running or pending are ignored, and `resync_en` reads low while running.
- R4: A restart is accepted only if both of the following hold since debug entry:
  - the latest capture had `scan_sys_bit` low;
  - the capture before it had `scan_sys_bit` high.

  The restart instruction is `tap_ir == 4'h4`.
- R5: Once accepted, the restart stays pending with `dbg_ack` high until `tap_state == 4'hC` (Run-Test/Idle). A later change of `tap_ir` does not cancel it.
- R6: `resume_pulse` is high in exactly the one cycle in which the block is pending and `tap_state == 4'hC`. `dbg_ack` is low after that edge.
- R7: Neither Run-Test/Idle nor the restart code produces `resume_pulse` while halted without a pending restart, or while running.
- R8: Entry to debug state discards the capture history. A restart selected straight after re-entry is refused until a new closing pair has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_req | input | 1 | Request to halt the core |
| tap_state | input | 4 | Current TAP state code; 4'hC is Run-Test/Idle |
| tap_ir | input | 4 | Current TAP instruction; 4'h4 is restart |
| scan_cap | input | 1 | Strobe: an instruction was loaded into the core |
| scan_sys_bit | input | 1 | Control bit of the loaded instruction (system speed) |
| dbg_ack | output | 1 | High while the core is in debug state |
| resume_pulse | output | 1 | One-cycle pulse when fetching resumes |
| resync_en | output | 1 | Control bit of the latest capture in debug state |

## Verification
The bench goes after the following corner cases:
- **Run-Test/Idle too early.** The TAP reaches Run-Test/Idle before any restart is pending. A design that resumed on Run-Test/Idle alone would release the core in the middle of the sequence.
- **Restart on the idle cycle.** The restart code and Run-Test/Idle arrive in the same cycle. A design that skipped the pending state would pulse one cycle early.
- **Broken closing order.** The closing pair is interrupted by a later system-speed capture. A design that remembered the pair too loosely would accept the restart.
- **Stale history after re-entry.** The restart is selected immediately after re-entry. A design that did not flush its history would resume without a new exit sequence.
- **Reset and changes while pending.** The bench resets the block while a restart is pending, and changes the TAP instruction while pending. A design that dropped the pending state on an instruction change would hang the core in debug.

// File: rtl/dbg_exit_pkg.sv
package dbg_exit_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DBG  = 2'd1,
    ST_PEND = 2'd2
  } exit_st_t;

  // A closing pair: previous load at system speed, latest load a plain branch.
  function automatic logic closing_pair(input logic prev_sys, input logic cur_sys);
    return prev_sys & ~cur_sys;
  endfunction
endpackage

// File: rtl/dbg_tap_decode.sv
module dbg_tap_decode #(
  parameter int TAP_W = 4,
  parameter int IR_W  = 4,
  parameter logic [TAP_W-1:0] IDLE_CODE    = 4'hC,
  parameter logic [IR_W-1:0]  RESTART_CODE = 4'h4
) (
  input  logic [TAP_W-1:0] tap_state,
  input  logic [IR_W-1:0]  tap_ir,
  output logic             at_idle,
  output logic             restart_sel
);
  function automatic logic code_hit_ir(input logic [IR_W-1:0] v, input logic [IR_W-1:0] c);
    return (v == c);
  endfunction

  function automatic logic code_hit_tap(input logic [TAP_W-1:0] v, input logic [TAP_W-1:0] c);
    return (v == c);
  endfunction

  assign at_idle     = code_hit_tap(tap_state, IDLE_CODE);
  assign restart_sel = code_hit_ir(tap_ir, RESTART_CODE);
endmodule

// File: rtl/dbg_load_hist.sv
module dbg_load_hist
  import dbg_exit_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic cap_en,
  input  logic sys_bit,
  output logic resync_en,
  output logic exit_ready
);
  logic prev_sys;

  always_ff @(posedge clk) begin
    if (rst || running) begin
      prev_sys   <= 1'b0;
      resync_en  <= 1'b0;
      exit_ready <= 1'b0;
    end else if (cap_en) begin
      prev_sys   <= sys_bit;
      resync_en  <= sys_bit;
      exit_ready <= closing_pair(prev_sys, sys_bit);
    end
  end

  // R3: a system-speed capture shows on the flag after the edge
  p_flag_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (cap_en && sys_bit && !running) |=> resync_en);

  // R4: readiness implies the latest load was not at system speed
  p_ready_low_last_r4: assert property (@(posedge clk) disable iff (rst)
    exit_ready |-> !resync_en);
endmodule

// File: rtl/dbg_exit_fsm.sv
module dbg_exit_fsm
  import dbg_exit_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     dbg_req,
  input  logic     restart_sel,
  input  logic     at_idle,
  input  logic     exit_ready,
  output exit_st_t st,
  output logic     dbg_ack,
  output logic     resume_pulse
);
  exit_st_t st_nxt;
  logic     go_resume;
  logic     go_pend;

  assign go_pend      = (st == ST_DBG) && restart_sel && exit_ready;
  assign go_resume    = (st == ST_PEND) && at_idle;
  assign resume_pulse = go_resume;

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_RUN:  if (dbg_req)   st_nxt = ST_DBG;
      ST_DBG:  if (go_pend)   st_nxt = ST_PEND;
      ST_PEND: if (go_resume) st_nxt = ST_RUN;
      default: st_nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_RUN;
      dbg_ack <= 1'b0;
    end else begin
      st      <= st_nxt;
      dbg_ack <= (st_nxt != ST_RUN);
    end
  end

  // R1: reset leaves acknowledge low
  p_ack_reset_r1: assert property (@(posedge clk) rst |=> !dbg_ack);
  // R2: a halt request from running raises acknowledge
  p_req_sets_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (!dbg_ack && dbg_req) |=> dbg_ack);
  // R5: pending without idle keeps the core halted
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PEND && !at_idle) |=> (dbg_ack && st == ST_PEND));
  // R6: pulse lasts one cycle and drops acknowledge
  p_resume_one_r6: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |=> !resume_pulse);
  p_ack_drop_r6: assert property (@(posedge clk) disable iff (rst)
    resume_pulse |=> !dbg_ack);
endmodule

// File: rtl/dbg_exit_seq.sv
module dbg_exit_seq
  import dbg_exit_pkg::*;
#(
  parameter int TAP_W = 4,
  parameter int IR_W  = 4,
  parameter logic [TAP_W-1:0] IDLE_CODE    = 4'hC,
  parameter logic [IR_W-1:0]  RESTART_CODE = 4'h4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dbg_req,
  input  logic [TAP_W-1:0] tap_state,
  input  logic [IR_W-1:0]  tap_ir,
  input  logic             scan_cap,
  input  logic             scan_sys_bit,
  output logic             dbg_ack,
  output logic             resume_pulse,
  output logic             resync_en
);
  exit_st_t st;
  logic     at_idle;
  logic     restart_sel;
  logic     exit_ready;
  logic     cap_en;
  logic     running;

  assign running = (st == ST_RUN);
  assign cap_en  = scan_cap && (st == ST_DBG);

  dbg_tap_decode #(
    .TAP_W(TAP_W), .IR_W(IR_W),
    .IDLE_CODE(IDLE_CODE), .RESTART_CODE(RESTART_CODE)
  ) u_dec (
    .tap_state(tap_state), .tap_ir(tap_ir),
    .at_idle(at_idle), .restart_sel(restart_sel)
  );

  dbg_load_hist u_hist (
    .clk(clk), .rst(rst), .running(running), .cap_en(cap_en),
    .sys_bit(scan_sys_bit), .resync_en(resync_en), .exit_ready(exit_ready)
  );

  dbg_exit_fsm u_fsm (
    .clk(clk), .rst(rst), .dbg_req(dbg_req), .restart_sel(restart_sel),
    .at_idle(at_idle), .exit_ready(exit_ready), .st(st),
    .dbg_ack(dbg_ack), .resume_pulse(resume_pulse)
  );

  // R7: no resume while the core runs
  p_no_resume_running_r7: assert property (@(posedge clk) disable iff (rst)
    !dbg_ack |-> !resume_pulse);
  // R3: flag reads low while running
  p_flag_low_running_r3: assert property (@(posedge clk) disable iff (rst)
    (!dbg_ack && !$past(dbg_ack) && !$past(rst)) |-> !resync_en);
endmodule

// File: tb/sim_dbg_exit_seq.sv
module sim_dbg_exit_seq;
  logic clk = 1'b0;
  logic rst, dbg_req, scan_cap, scan_sys_bit;
  logic [3:0] tap_state, tap_ir;
  logic dbg_ack, resume_pulse, resync_en;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dbg_exit_seq u0 (
    .clk(clk), .rst(rst), .dbg_req(dbg_req), .tap_state(tap_state),
    .tap_ir(tap_ir), .scan_cap(scan_cap), .scan_sys_bit(scan_sys_bit),
    .dbg_ack(dbg_ack), .resume_pulse(resume_pulse), .resync_en(resync_en)
  );

  // fields: req | tap[4] | ir[4] | cap | sys | exp_resume | exp_ack | exp_resync
  localparam int NV = 31;
  localparam logic [13:0] VEC [NV] = '{
    14'b1_0001_0010_0_0_0_1_0,  // 0  enter debug
    14'b0_1100_0010_0_0_0_1_0,  // 1  idle while halted
    14'b0_0001_0010_1_1_0_1_1,  // 2  system-speed load
    14'b0_0001_0010_1_0_0_1_0,  // 3  branch load
    14'b0_0001_0100_0_0_0_1_0,  // 4  restart selected
    14'b0_0001_0010_0_0_0_1_0,  // 5  ir changes, still pending
    14'b0_1100_0010_0_0_1_0_0,  // 6  resume
    14'b0_1100_0010_0_0_0_0_0,  // 7  idle while running
    14'b1_0001_0010_0_0_0_1_0,  // 8  re-enter
    14'b0_0001_0100_0_0_0_1_0,  // 9  stale restart refused
    14'b0_1100_0100_0_0_0_1_0,  // 10
    14'b0_0001_0010_1_0_0_1_0,  // 11 lone branch
    14'b0_0001_0100_0_0_0_1_0,  // 12 refused
    14'b0_1100_0010_0_0_0_1_0,  // 13
    14'b0_0001_0010_1_1_0_1_1,  // 14
    14'b0_0001_0010_1_1_0_1_1,  // 15
    14'b0_0001_0010_1_0_0_1_0,  // 16 pair complete
    14'b0_0001_0010_1_1_0_1_1,  // 17 pair broken
    14'b0_0001_0100_0_0_0_1_1,  // 18 refused
    14'b0_1100_0010_0_0_0_1_1,  // 19
    14'b0_0001_0010_1_0_0_1_0,  // 20 pair complete again
    14'b0_0001_0100_0_0_0_1_0,  // 21 pending
    14'b1_0001_0010_0_0_0_1_0,  // 22 request while pending
    14'b0_1100_0010_0_0_1_0_0,  // 23 resume
    14'b0_0001_0010_1_1_0_0_0,  // 24 capture while running
    14'b0_1100_0100_0_0_0_0_0,  // 25 restart+idle while running
    14'b1_0001_0010_0_0_0_1_0,  // 26 enter
    14'b0_0001_0010_1_1_0_1_1,  // 27
    14'b0_0001_0010_1_0_0_1_0,  // 28
    14'b0_1100_0100_0_0_0_1_0,  // 29 restart on idle cycle: pending only
    14'b0_1100_0100_0_0_1_0_0   // 30 resume next cycle
  };

  function automatic string req_tag(input int i);
    if (i == 0 || i == 22 || i == 26) return "R2";
    if (i == 2 || i == 3 || i == 24 || i == 27 || i == 28) return "R3";
    if (i == 4 || i == 5 || i == 21 || i == 29) return "R5";
    if (i == 6 || i == 23 || i == 30) return "R6";
    if (i == 1 || i == 7 || i == 25) return "R7";
    if (i >= 8 && i <= 10) return "R8";
    return "R4";
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic rq, input logic [3:0] ts, input logic [3:0] ir,
                       input logic cp, input logic sb);
    @(negedge clk);
    dbg_req = rq; tap_state = ts; tap_ir = ir; scan_cap = cp; scan_sys_bit = sb;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; dbg_req = 1'b0; tap_state = 4'h1; tap_ir = 4'h2;
    scan_cap = 1'b0; scan_sys_bit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset ack", dbg_ack, 1'b0);
    check("R1", "reset resume", resume_pulse, 1'b0);
    check("R1", "reset resync", resync_en, 1'b0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13], VEC[i][12:9], VEC[i][8:5], VEC[i][4], VEC[i][3]);
      #1;
      check(req_tag(i), $sformatf("v%0d resume", i), resume_pulse, VEC[i][2]);
      @(posedge clk);
      #1;
      check(req_tag(i), $sformatf("v%0d ack", i), dbg_ack, VEC[i][1]);
      check(req_tag(i), $sformatf("v%0d resync", i), resync_en, VEC[i][0]);
    end

    // Reset while a restart is pending drops it (R1)
    drive(1'b1, 4'h1, 4'h2, 1'b0, 1'b0);
    drive(1'b0, 4'h1, 4'h2, 1'b1, 1'b1);
    drive(1'b0, 4'h1, 4'h2, 1'b1, 1'b0);
    drive(1'b0, 4'h1, 4'h4, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R5", "pending before reset ack", dbg_ack, 1'b1);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R1", "ack after reset in pending", dbg_ack, 1'b0);
    @(negedge clk) rst = 1'b0;
    drive(1'b0, 4'hC, 4'h2, 1'b0, 1'b0);
    #1;
    check("R1", "no resume after reset", resume_pulse, 1'b0);
    @(posedge clk); #1;
    check("R1", "ack stays low", dbg_ack, 1'b0);
    check("R1", "resync low", resync_en, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule